// File: doc/BRIEF.md
# Ethernet PAUSE Frame Detector

This block sits on the receive side of an Ethernet MAC. It watches the bytes of an incoming frame after the preamble and start-of-frame delimiter have been stripped. It decides whether the frame is a MAC control PAUSE request aimed at this station.

The fields are parsed as they arrive on the wire: destination address, source address, type, opcode and then the 16-bit pause quantum. When the receive path signals the end of the frame, the block combines the field matches with three more conditions:

- the good/bad status that stands in for the CRC check;
- a minimum length;
- the two mode enables, full-duplex and flow-control.

A qualifying frame produces a one-cycle pulse, and the captured quantum is presented alongside it for the pause timer.

The destination may be either the reserved control multicast address or the station's own programmed address. The source address can hold any value and is skipped. The end-of-frame marker comes in a cycle of its own after the last byte, and the status is valid in that cycle.

Top module: `pause_detect`

## Requirements
- R1: After reset, `pause_det` is 0 and `pause_dur` is 0x0000.
- R2: A pause is reported only when `full_duplex` and `flow_ctrl_en` are both 1 in the end-of-frame cycle; with either at 0 a frame that is otherwise valid gives no pulse.
- R3: A frame whose bytes 0..5 are 01 80 C2 00 00 01 (first byte first) passes the destination check.
- R4: A frame whose bytes 0..5 equal `station_addr`, bits 47:40 first, passes the destination check; any other destination is rejected.
- R5: Bytes 12 and 13 must be 0x88 then 0x08, or the frame is rejected.
- R6: Bytes 14 and 15 must be 0x00 then 0x01, or the frame is rejected.
- R7: Bytes 16 (upper half) and 17 (lower half) form the pause duration; any value from 0x0000 to 0xFFFF is accepted and appears on `pause_dur` in the same cycle as the pulse.
- R8: Bytes 6..11 (source address) have no effect on detection or on the captured duration.
- R9: When `frame_good` is 0 in the end-of-frame cycle, no pause is reported.
- R10: A frame of fewer than 18 bytes is never reported; 18 bytes or more (padding allowed) can be.
- R11: `pause_det` is high for exactly the one cycle after the `frame_end` cycle. `pause_dur` changes only with a detection and holds through rejected frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | `byte_data` carries a frame byte this cycle |
| byte_data | input | 8 | Frame byte |
| frame_start | input | 1 | Marks byte 0 of a frame, together with `byte_valid` |
| frame_end | input | 1 | End-of-frame strobe, in a cycle after the last byte |
| frame_good | input | 1 | Receive status valid with `frame_end`: 1 means the frame is good |
| station_addr | input | 48 | Station's physical address |
| full_duplex | input | 1 | Full-duplex mode enable |
| flow_ctrl_en | input | 1 | Flow-control enable |
| pause_det | output | 1 | One-cycle PAUSE detected pulse |
| pause_dur | output | 16 | Captured pause duration |

## Verification
The assertions check on every cycle that a pulse follows only an end-of-frame cycle and only with both enables set. They also check that the status was good, that at least 18 bytes arrived, and that the duration register moves only together with a pulse.

Which field values are accepted or rejected can only be shown by the bench's scenarios. These cover the two destination forms, corrupted type, opcode and address bytes, varied source addresses, extreme duration values, and short and padded frames.

// File: rtl/pd_pkg.sv
package pd_pkg;
   localparam logic [47:0] PAUSE_MC_DA   = 48'h0180_C200_0001;
   localparam logic [15:0] MAC_CTRL_TYPE = 16'h8808;
   localparam logic [15:0] PAUSE_OPCODE  = 16'h0001;
   localparam int DA_OFS    = 0;
   localparam int TYPE_OFS  = 12;
   localparam int OP_OFS    = 14;
   localparam int DUR_OFS   = 16;
   localparam int MIN_BYTES = 18;

   typedef struct packed {
      logic mc_da;
      logic st_da;
      logic typ;
      logic op;
   } match_t;
endpackage

// File: rtl/pd_byte_index.sv
module pd_byte_index #(
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_valid,
   input  logic             frame_start,
   output logic [IDX_W-1:0] eff_idx,
   output logic [IDX_W-1:0] count
);
   localparam logic [IDX_W-1:0] SAT = {IDX_W{1'b1}};

   assign eff_idx = frame_start ? '0 : count;

   always_ff @(posedge clk) begin
      if (!rst_n)
         count <= '0;
      else if (byte_valid) begin
         if (frame_start)
            count <= IDX_W'(1);
         else if (count != SAT)
            count <= count + IDX_W'(1);
      end
   end

   assert_cnt_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && frame_start) |=> (count == IDX_W'(1)));
endmodule

// File: rtl/pd_field_cmp.sv
module pd_field_cmp #(
   parameter int IDX_W  = 6,
   parameter int OFFSET = 0,
   parameter int NB     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_valid,
   input  logic             frame_start,
   input  logic [IDX_W-1:0] eff_idx,
   input  logic [7:0]       byte_data,
   input  logic [NB*8-1:0]  expect_val,
   output logic             ok
);
   localparam int LAST = OFFSET + NB;

   if (LAST >= (1 << IDX_W)) begin : g_chk
      $error("pd_field_cmp: field end does not fit the index width");
   end

   logic [IDX_W-1:0] rel;
   logic             in_range;
   logic             first;
   logic [7:0]       exp_byte;

   assign rel      = eff_idx - IDX_W'(OFFSET);
   assign in_range = rel < IDX_W'(NB);
   assign first    = rel == '0;

   always_comb begin
      exp_byte = '0;
      for (int j = 0; j < NB; j++)
         if (rel == IDX_W'(j))
            exp_byte = expect_val[(NB-1-j)*8 +: 8];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ok <= 1'b0;
      else if (byte_valid) begin
         if (in_range)
            ok <= (first ? 1'b1 : ok) & (byte_data == exp_byte);
         else if (frame_start)
            ok <= 1'b0;
      end
   end
endmodule

// File: rtl/pause_detect.sv
module pause_detect #(
   parameter int IDX_W          = 6,
   parameter bit ACCEPT_STATION = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        byte_valid,
   input  logic [7:0]  byte_data,
   input  logic        frame_start,
   input  logic        frame_end,
   input  logic        frame_good,
   input  logic [47:0] station_addr,
   input  logic        full_duplex,
   input  logic        flow_ctrl_en,
   output logic        pause_det,
   output logic [15:0] pause_dur
);
   import pd_pkg::*;

   localparam logic [IDX_W-1:0] MIN_CNT = IDX_W'(MIN_BYTES);

   if ((1 << IDX_W) <= MIN_BYTES) begin : g_wchk
      $error("pause_detect: IDX_W too small for the PAUSE field layout");
   end

   logic [IDX_W-1:0] eff_idx;
   logic [IDX_W-1:0] count;
   match_t           m;
   logic [15:0]      dur_sh;
   logic             det_now;

   pd_byte_index #(.IDX_W(IDX_W)) u_idx (
      .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid),
      .frame_start(frame_start), .eff_idx(eff_idx), .count(count));

   pd_field_cmp #(.IDX_W(IDX_W), .OFFSET(DA_OFS), .NB(6)) u_mc (
      .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid),
      .frame_start(frame_start), .eff_idx(eff_idx), .byte_data(byte_data),
      .expect_val(PAUSE_MC_DA), .ok(m.mc_da));

   if (ACCEPT_STATION) begin : g_st
      pd_field_cmp #(.IDX_W(IDX_W), .OFFSET(DA_OFS), .NB(6)) u_st (
         .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid),
         .frame_start(frame_start), .eff_idx(eff_idx), .byte_data(byte_data),
         .expect_val(station_addr), .ok(m.st_da));
   end else begin : g_nost
      assign m.st_da = 1'b0;
   end

   pd_field_cmp #(.IDX_W(IDX_W), .OFFSET(TYPE_OFS), .NB(2)) u_typ (
      .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid),
      .frame_start(frame_start), .eff_idx(eff_idx), .byte_data(byte_data),
      .expect_val(MAC_CTRL_TYPE), .ok(m.typ));

   pd_field_cmp #(.IDX_W(IDX_W), .OFFSET(OP_OFS), .NB(2)) u_op (
      .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid),
      .frame_start(frame_start), .eff_idx(eff_idx), .byte_data(byte_data),
      .expect_val(PAUSE_OPCODE), .ok(m.op));

   always_ff @(posedge clk) begin
      if (!rst_n)
         dur_sh <= '0;
      else if (byte_valid) begin
         if (eff_idx == IDX_W'(DUR_OFS))
            dur_sh[15:8] <= byte_data;
         else if (eff_idx == IDX_W'(DUR_OFS + 1))
            dur_sh[7:0] <= byte_data;
      end
   end

   assign det_now = frame_end && frame_good && full_duplex && flow_ctrl_en
                    && (count >= MIN_CNT) && (m.mc_da || m.st_da)
                    && m.typ && m.op;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pause_det <= 1'b0;
         pause_dur <= '0;
      end else begin
         pause_det <= det_now;
         if (det_now)
            pause_dur <= dur_sh;
      end
   end

   assert_enables_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pause_det |-> $past(full_duplex && flow_ctrl_en));
   assert_good_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pause_det |-> $past(frame_good));
   assert_min_length_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pause_det |-> ($past(count) >= MIN_CNT));
   assert_after_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
      pause_det |-> $past(frame_end));
   assert_dur_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !pause_det |-> $stable(pause_dur));
endmodule

// File: tb/sim_pause_detect.sv
module sim_pause_detect;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        byte_valid = 1'b0;
   logic [7:0]  byte_data = '0;
   logic        frame_start = 1'b0;
   logic        frame_end = 1'b0;
   logic        frame_good = 1'b0;
   logic [47:0] station_addr = 48'h02AB_CD12_3456;
   logic        full_duplex = 1'b1;
   logic        flow_ctrl_en = 1'b1;
   logic        pause_det;
   logic [15:0] pause_dur;

   int tests = 0;
   int fails = 0;
   logic [15:0] model_dur = '0;
   logic [7:0]  fr [0:63];
   bit          done = 1'b0;

   typedef struct {
      bit          det;
      logic [15:0] dur;
      string       tag;
   } exp_t;
   exp_t sb [$];

   always #10 clk = ~clk;

   pause_detect u0 (
      .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
      .frame_start(frame_start), .frame_end(frame_end), .frame_good(frame_good),
      .station_addr(station_addr), .full_duplex(full_duplex),
      .flow_ctrl_en(flow_ctrl_en), .pause_det(pause_det), .pause_dur(pause_dur));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
      tests++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, expv);
      end
   endtask

   task automatic build(input logic [47:0] da, input logic [47:0] sa,
                        input logic [15:0] typ, input logic [15:0] op,
                        input logic [15:0] dur);
      for (int i = 0; i < 64; i++) fr[i] = 8'(i * 7 + 3);
      for (int i = 0; i < 6; i++) begin
         fr[i]   = da[(5-i)*8 +: 8];
         fr[6+i] = sa[(5-i)*8 +: 8];
      end
      fr[12] = typ[15:8]; fr[13] = typ[7:0];
      fr[14] = op[15:8];  fr[15] = op[7:0];
      fr[16] = dur[15:8]; fr[17] = dur[7:0];
   endtask

   task automatic send(input int len, input bit good, input string tag);
      exp_t e;
      logic [47:0] da;
      bit ok;
      da = {fr[0], fr[1], fr[2], fr[3], fr[4], fr[5]};
      ok = full_duplex && flow_ctrl_en && good && (len >= 18)
           && (da == 48'h0180_C200_0001 || da == station_addr)
           && fr[12] == 8'h88 && fr[13] == 8'h08
           && fr[14] == 8'h00 && fr[15] == 8'h01;
      if (ok) model_dur = {fr[16], fr[17]};
      e.det = ok; e.dur = model_dur; e.tag = tag;
      sb.push_back(e);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         byte_valid = 1'b1; byte_data = fr[i]; frame_start = (i == 0);
      end
      @(negedge clk);
      byte_valid = 1'b0; frame_start = 1'b0; frame_end = 1'b1; frame_good = good;
      @(negedge clk);
      frame_end = 1'b0; frame_good = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin : monitor
      exp_t e;
      forever begin
         @(posedge clk);
         if (rst_n && frame_end) begin
            @(negedge clk);
            if (sb.size() == 0) check("R11 unexpected end", 1, 0);
            else begin
               e = sb.pop_front();
               check({e.tag, " pulse"}, 32'(pause_det), 32'(e.det));
               check({e.tag, " duration"}, 32'(pause_dur), 32'(e.dur));
            end
            @(negedge clk);
            check("R11 pulse width", 32'(pause_det), 0);
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   localparam logic [47:0] MC = 48'h0180_C200_0001;

   initial begin : driver
      repeat (3) @(negedge clk);
      check("R1 reset pulse", 32'(pause_det), 0);
      check("R1 reset duration", 32'(pause_dur), 0);
      rst_n = 1'b1;
      @(negedge clk);

      build(MC, 48'h0011_2233_4455, 16'h8808, 16'h0001, 16'h1234);
      send(18, 1, "R3 multicast DA R7");
      build(station_addr, 48'h0011_2233_4455, 16'h8808, 16'h0001, 16'hFFFF);
      send(20, 1, "R4 station DA R7 max");
      build(48'h0180_C200_0002, 48'h0011_2233_4455, 16'h8808, 16'h0001, 16'h5555);
      send(18, 1, "R4 other DA R11 hold");
      build(station_addr ^ 48'h0100_0000_0000, 48'h0, 16'h8808, 16'h0001, 16'h5555);
      send(18, 1, "R4 station DA bit flip");
      build(MC, 48'h0, 16'h8809, 16'h0001, 16'h5555);
      send(18, 1, "R5 bad type low");
      build(MC, 48'h0, 16'h0808, 16'h0001, 16'h5555);
      send(18, 1, "R5 bad type high");
      build(MC, 48'h0, 16'h8808, 16'h0002, 16'h5555);
      send(18, 1, "R6 bad opcode");
      build(MC, 48'h0, 16'h8808, 16'h0101, 16'h5555);
      send(18, 1, "R6 bad opcode high");
      build(MC, 48'hFFFF_FFFF_FFFF, 16'h8808, 16'h0001, 16'h0000);
      send(18, 1, "R7 zero duration R8");
      build(MC, 48'h0180_C200_0001, 16'h8808, 16'h0001, 16'hABCD);
      send(18, 1, "R8 SA equals DA");
      build(MC, 48'h0, 16'h8808, 16'h0001, 16'h7777);
      send(18, 0, "R9 bad status");
      full_duplex = 1'b0;
      send(18, 1, "R2 half duplex");
      full_duplex = 1'b1; flow_ctrl_en = 1'b0;
      send(18, 1, "R2 flow control off");
      flow_ctrl_en = 1'b1;
      build(MC, 48'h0, 16'h8808, 16'h0001, 16'h4242);
      send(17, 1, "R10 17 bytes");
      send(6, 1, "R10 6 bytes");
      send(18, 1, "R10 18 bytes");
      build(station_addr, 48'h1, 16'h8808, 16'h0001, 16'h0F0F);
      send(64, 1, "R10 padded 64");

      repeat (4) @(negedge clk);
      check("R11 queue drained", 32'(sb.size()), 0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule